// File: doc/BRIEF.md
# Snapshot-Latched 64-bit Timestamp Counter

This block keeps a free-running 64-bit timestamp on a 32-bit register bus. A prescaler field in the control word sets how many input clocks pass between increments. The count wraps modulo 2^64 and never stops.

A 64-bit value cannot be read in one bus access, and the count may carry between two half reads. Software therefore first writes a snapshot command, which latches all 64 bits at one clock edge. It then reads the two latched halves at leisure, high half first. To preset the count, software stages a value in two load halves and then writes a load command that commits the whole value at one edge.

Writes take effect at the clock edge on which `bus_valid` and `bus_write` are high. Reads are combinational from `bus_addr` while `bus_valid` is high and `bus_write` is low.

Top module: `ts_counter`

## Requirements
- R1: While reset is asserted, every register offset reads zero: control, count, load and snapshot halves.
- R2: With prescaler value N in control bits [31:16], the count rises by exactly one every N+1 clocks. With N=0 it rises on every clock. A control write changes N from the edge on which it is written.
- R3: A control write with bit 0 = 1 and bit 1 = 0 copies the full 64-bit count, as it stood just before that edge, into the snapshot halves (0x7C low, 0x80 high).
- R4: The snapshot halves keep their value while the count runs, until the next snapshot command.
- R5: A control write with bits [1:0] = 2'b11 copies the load halves (0x74 low, 0x78 high) into the count at that edge. The prescaler phase restarts, so the first increment after a load comes N+1 clocks later.
- R6: Control bits 0 and 1 are one-cycle strobes that read back as 0. Control reads return the stored prescaler in [31:16] and zeros elsewhere.
- R7: The count wraps from all ones to zero and keeps counting.
- R8: Writes to the count halves (0x6C, 0x70) or the snapshot halves (0x7C, 0x80) have no effect. A control write with bit 1 = 1 and bit 0 = 0 only updates the prescaler.
- R9: The load halves read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
A wrong prescaler phase shows at the count offsets within N+1 clocks: the increment lands a cycle early or late relative to the last load. A snapshot latched one edge off, or a low half latched from a different edge than the high half, shows as a snapshot value that disagrees with the running count sampled in the cycle of the command. Load and wrap faults show at the count offsets on the first or second read after the command. Because the bench compares every read against a reference model in the same cycle, a divergence is reported in the cycle it first becomes visible.

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'('h68);
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'('h6C);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] A_LD_LO   = ADDR_W'('h74);
  localparam logic [ADDR_W-1:0] A_LD_HI   = ADDR_W'('h78);
  localparam logic [ADDR_W-1:0] A_SNP_LO  = ADDR_W'('h7C);
  localparam logic [ADDR_W-1:0] A_SNP_HI  = ADDR_W'('h80);

  logic [CNT_W-1:0]   cnt_q, load_q, snap_q;
  logic [PRESC_W-1:0] presc_q, phase_q;

  wire wr       = bus_valid & bus_write;
  wire wr_ctrl  = wr & (bus_addr == A_CTRL);
  wire cmd_snap = wr_ctrl & bus_wdata[0] & ~bus_wdata[1];
  wire cmd_load = wr_ctrl & bus_wdata[0] & bus_wdata[1];
  wire tick     = (phase_q >= presc_q);
  wire unused_wdata = &{1'b0, bus_wdata[DATA_W-PRESC_W-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (wr_ctrl) begin
      presc_q <= bus_wdata[DATA_W-1 -: PRESC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (cmd_load) begin
      phase_q <= '0;
      cnt_q   <= load_q;
    end else if (tick) begin
      phase_q <= '0;
      cnt_q   <= cnt_q + CNT_W'(1);
    end else begin
      phase_q <= phase_q + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr) begin
      if (bus_addr == A_LD_LO) load_q[DATA_W-1:0]     <= bus_wdata;
      if (bus_addr == A_LD_HI) load_q[CNT_W-1:DATA_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (cmd_snap) snap_q <= cnt_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_CTRL:   bus_rdata = {presc_q, {(DATA_W-PRESC_W){1'b0}}};
        A_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
        A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
        A_LD_LO:  bus_rdata = load_q[DATA_W-1:0];
        A_LD_HI:  bus_rdata = load_q[CNT_W-1:DATA_W];
        A_SNP_LO: bus_rdata = snap_q[DATA_W-1:0];
        A_SNP_HI: bus_rdata = snap_q[CNT_W-1:DATA_W];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

module ts_counter_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [1:0]          bus_cmd,
  input logic [2*DATA_W-1:0] cnt_q,
  input logic [2*DATA_W-1:0] load_q,
  input logic [2*DATA_W-1:0] snap_q
);
  localparam int CNT_W = 2 * DATA_W;
  wire ctl = bus_valid && bus_write && (bus_addr == ADDR_W'('h68));
  wire ld  = ctl && (bus_cmd == 2'b11);
  wire sn  = ctl && (bus_cmd == 2'b01);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sn |=> snap_q == $past(cnt_q));
  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sn |=> $stable(snap_q));
  // R5
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(load_q));
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == '1) |=> (cnt_q == '0 || cnt_q == '1));
endmodule

bind ts_counter ts_counter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_cmd(bus_wdata[1:0]),
  .cnt_q(cnt_q), .load_q(load_q), .snap_q(snap_q)
);

// File: tb/ts_counter_tb.sv
module ts_counter_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint unsigned m_cnt = 0, m_load = 0, m_snap = 0;
  int m_presc = 0, m_phase = 0;
  bit m_ctl, m_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_counter u_dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
                    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // Reference model, updated at every rising edge from the bus inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_snap = 0; m_presc = 0; m_phase = 0;
    end else begin
      m_ctl  = bus_valid && bus_write && bus_addr == 8'h68;
      m_tick = (m_phase >= m_presc);
      if (m_ctl && bus_wdata[1:0] == 2'b01) m_snap = m_cnt;
      if (m_ctl && bus_wdata[1:0] == 2'b11) begin m_cnt = m_load; m_phase = 0; end
      else if (m_tick) begin m_cnt = m_cnt + 1; m_phase = 0; end
      else m_phase = m_phase + 1;
      if (bus_valid && bus_write && bus_addr == 8'h74) m_load[31:0]  = bus_wdata;
      if (bus_valid && bus_write && bus_addr == 8'h78) m_load[63:32] = bus_wdata;
      if (m_ctl) m_presc = int'(bus_wdata[31:16]);
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h68: return {m_presc[15:0], 16'h0};
      8'h6C: return m_cnt[31:0];
      8'h70: return m_cnt[63:32];
      8'h74: return m_load[31:0];
      8'h78: return m_load[63:32];
      8'h7C: return m_snap[31:0];
      8'h80: return m_snap[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // Read one register this cycle and compare with the model
  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
    #1 check(tag, bus_rdata, model_read(a));
  endtask

  // Read with an additional literal expectation
  task automatic rd_lit(input logic [7:0] a, input logic [31:0] lit, input string tag);
    rd(a, tag);
    check(tag, bus_rdata, lit);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) rd((i % 2) ? 8'h70 : 8'h6C, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    rd_lit(8'h68, 32'h0, "R1 ctrl");
    rd_lit(8'h6C, 32'h0, "R1 cnt_lo");
    rd_lit(8'h70, 32'h0, "R1 cnt_hi");
    rd_lit(8'h74, 32'h0, "R1 load_lo");
    rd_lit(8'h78, 32'h0, "R1 load_hi");
    rd_lit(8'h7C, 32'h0, "R1 snap_lo");
    rd_lit(8'h80, 32'h0, "R1 snap_hi");
    @(negedge clk); rst_n = 1'b1;

    // R2: N=0 counts every clock
    run(12, "R2 div1");

    // R9: load halves read back
    wr(8'h74, 32'h89AB_CDEF);
    wr(8'h78, 32'h0123_4567);
    rd_lit(8'h74, 32'h89AB_CDEF, "R9 load_lo");
    rd_lit(8'h78, 32'h0123_4567, "R9 load_hi");

    // R5: load with N=3, phase restarts
    wr(8'h68, 32'h0003_0003);
    rd_lit(8'h6C, 32'h89AB_CDEF, "R5 load applied");
    rd_lit(8'h70, 32'h0123_4567, "R5 load hi");
    rd_lit(8'h6C, 32'h89AB_CDEF, "R5 no early step");
    rd_lit(8'h6C, 32'h89AB_CDEF, "R5 no early step");
    rd_lit(8'h6C, 32'h89AB_CDF0, "R5 first step after N+1");

    // R6: command bits read as zero, prescaler kept
    rd_lit(8'h68, 32'h0003_0000, "R6 ctrl readback");
    run(10, "R2 div4");

    // R3 / R4: snapshot and hold
    wr(8'h68, 32'h0003_0001);
    rd_lit(8'h68, 32'h0003_0000, "R6 after snapshot");
    run(25, "R4 running");
    rd(8'h80, "R4 snap_hi held");
    rd(8'h7C, "R3 snap_lo");
    check("R4 snap differs from running count", (m_snap != m_cnt) ? 32'h1 : 32'h0, 32'h1);

    // R8: ignored writes
    wr(8'h6C, 32'hDEAD_BEEF);
    wr(8'h70, 32'hDEAD_BEEF);
    wr(8'h7C, 32'h5555_5555);
    wr(8'h80, 32'hAAAA_AAAA);
    wr(8'h68, 32'h0003_0002);
    rd(8'h7C, "R8 snap_lo unchanged");
    rd(8'h80, "R8 snap_hi unchanged");
    rd(8'h70, "R8 cnt_hi unchanged");
    rd(8'h6C, "R8 cnt_lo unchanged");
    run(8, "R8 count continues");

    // R7: wrap with N=0
    wr(8'h74, 32'hFFFF_FFFD);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h68, 32'h0000_0003);
    rd_lit(8'h6C, 32'hFFFF_FFFD, "R7 preset");
    rd_lit(8'h6C, 32'hFFFF_FFFE, "R7 step");
    rd_lit(8'h70, 32'hFFFF_FFFF, "R7 hi before wrap");
    rd_lit(8'h70, 32'h0000_0000, "R7 hi after wrap");
    rd_lit(8'h6C, 32'h0000_0001, "R7 lo after wrap");

    // R2: larger divider, snapshot while running
    wr(8'h68, 32'h000A_0000);
    run(60, "R2 div11");
    wr(8'h68, 32'h000A_0001);
    run(15, "R3 running");
    rd(8'h80, "R3 snap_hi");
    rd(8'h7C, "R3 snap_lo");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule